// File: doc/BRIEF.md
# Closed-Page SDRAM Random Read Sequencer

This block drives the command and address pins of an SDRAM so that each read request is served as one isolated random access. On every accepted read it first closes whatever row may be open with a precharge, then opens the requested row with an activate, then issues a read to the requested column. It then raises a one-cycle valid strobe in the cycle where the first data word is on the data pins. Between commands it drives the no-operation code. All waits are timed by one down-counter that is reloaded at each command. A second counter guards the minimum row-open time. The read latency is therefore fixed at T_RP + T_RCD + T_CL cycles, which is 11 cycles with the default 3/3/5/8 timing. The timing parameters can be set for a slower 5/5/5/12 part. With that part the row-open guard can hold off the next precharge.

On request the block also performs a refresh. It precharges, waits T_RP, issues a refresh command, and then stays busy for T_RAS cycles. A refresh request is taken only while the block is idle, and it wins over a read request that arrives in the same cycle. While busy, the block ignores every request.

The controller moves through six states. IDLE waits for a request. GUARD holds an accepted request until the last row has been open for T_RAS cycles. PRE_WAIT follows the precharge. ACT_WAIT follows the activate. READ_WAIT follows the read. REF_WAIT follows the refresh command. The transitions are:
- IDLE to PRE_WAIT on a request when the row guard has expired.
- IDLE to GUARD on a request when the row guard has not expired.
- GUARD to PRE_WAIT when the row guard expires.
- PRE_WAIT to ACT_WAIT after T_RP on a read, or PRE_WAIT to REF_WAIT after T_RP on a refresh.
- ACT_WAIT to READ_WAIT after T_RCD.
- READ_WAIT to IDLE after T_CL, with the valid strobe.
- REF_WAIT to IDLE after T_RAS.

Top module: `sdram_rd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, sd_cmd is NOP (3'b111), busy is 0 and rd_valid is 0.
- R2: sd_cmd carries {ras_n, cas_n, we_n} with NOP=3'b111, PRECHARGE=3'b010, ACTIVATE=3'b011, READ=3'b101 and REFRESH=3'b001. For a read, ACTIVATE with the row on sd_addr follows the PRECHARGE by exactly T_RP cycles, and READ with the column (zero-extended) on sd_addr follows the ACTIVATE by exactly T_RCD cycles. Every other cycle is NOP, and sd_addr is zero on NOP, PRECHARGE and REFRESH.
- R3: rd_valid is high for exactly one cycle, T_CL cycles after the READ command. The PRECHARGE appears in the cycle after the request is sampled whenever the row guard allows it, so the total read latency from PRECHARGE to rd_valid is T_RP+T_RCD+T_CL cycles.
- R4: A PRECHARGE is never issued less than T_RAS cycles after the last ACTIVATE or REFRESH. If a request arrives earlier, the PRECHARGE is delayed to exactly T_RAS cycles after that command.
- R5: A refresh issues PRECHARGE, then REFRESH exactly T_RP cycles later. The block stays busy for T_RAS cycles counted from the REFRESH cycle and raises no rd_valid.
- R6: busy is high from the cycle after a request is sampled up to the cycle before rd_valid, or up to the end of the refresh wait. busy is low in the rd_valid cycle. Requests sampled while busy have no effect on sd_cmd, sd_addr or rd_valid.
- R7: When ref_req and rd_req are sampled high together while idle, a refresh is performed and no read occurs.
- R8: With T_RP=5, T_RCD=5, T_CL=5 and T_RAS=12, the same ordering, spacing and row guard hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, sampled while idle |
| rd_row | input | ROW_W | Row address of the read |
| rd_col | input | COL_W | Column address of the read |
| ref_req | input | 1 | Refresh request, sampled while idle |
| sd_cmd | output | 3 | Command bus {ras_n, cas_n, we_n} |
| sd_addr | output | ADDR_W | Address bus, max(ROW_W, COL_W) bits |
| busy | output | 1 | Sequence in progress; requests ignored |
| rd_valid | output | 1 | First read data word is valid |

## Verification
The assertions assume that the requests are synchronous to clk. They also assume that every timing parameter is at least 1, so that each wait counter is loaded with a non-negative value. The stimulus raises a request only in a cycle where busy is low, or else as deliberate noise during a busy window whose effect is checked at the ports. The stimulus never raises a request in the cycle where the sequence ends unless it means to start the next one back to back. The slow-part instance is driven only while the fast instance is idle, so each request is unambiguous.

// File: rtl/sdram_rd_seq_pkg.sv
package sdram_rd_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'b111,
        CMD_PRE  = 3'b010,
        CMD_ACT  = 3'b011,
        CMD_READ = 3'b101,
        CMD_REF  = 3'b001
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_PRE,
        ST_ACT,
        ST_READ,
        ST_REF
    } seq_state_e;

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_rd_seq_pkg::*;
#(
    parameter int T_CL   = 5,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 8,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int TW     = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              ref_req,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              wait_done,
    input  logic              ras_done,
    output logic              wait_load,
    output logic [TW-1:0]     wait_val,
    output logic              ras_load,
    output logic [2:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              valid
);

    seq_state_e        state_q, state_d;
    sd_cmd_e           cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              valid_q, valid_d;
    logic              op_ref_q, op_ref_d;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              capture;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_ref_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            op_ref_q <= op_ref_d;
        end
    end

    // Address capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (capture) begin
            row_q <= rd_row;
            col_q <= rd_col;
        end
    end

    // Next state and next command
    always_comb begin
        state_d   = state_q;
        op_ref_d  = op_ref_q;
        cmd_d     = CMD_NOP;
        addr_d    = '0;
        valid_d   = 1'b0;
        wait_load = 1'b0;
        wait_val  = '0;
        ras_load  = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req || rd_req) begin
                    op_ref_d = ref_req;
                    capture  = !ref_req;
                    if (ras_done) begin
                        state_d   = ST_PRE;
                        cmd_d     = CMD_PRE;
                        wait_load = 1'b1;
                        wait_val  = TW'(T_RP - 1);
                    end else begin
                        state_d = ST_GUARD;
                    end
                end
            end
            ST_GUARD: begin
                if (ras_done) begin
                    state_d   = ST_PRE;
                    cmd_d     = CMD_PRE;
                    wait_load = 1'b1;
                    wait_val  = TW'(T_RP - 1);
                end
            end
            ST_PRE: begin
                if (wait_done) begin
                    wait_load = 1'b1;
                    ras_load  = 1'b1;
                    if (op_ref_q) begin
                        state_d  = ST_REF;
                        cmd_d    = CMD_REF;
                        wait_val = TW'(T_RAS - 1);
                    end else begin
                        state_d  = ST_ACT;
                        cmd_d    = CMD_ACT;
                        addr_d   = ADDR_W'(row_q);
                        wait_val = TW'(T_RCD - 1);
                    end
                end
            end
            ST_ACT: begin
                if (wait_done) begin
                    state_d   = ST_READ;
                    cmd_d     = CMD_READ;
                    addr_d    = ADDR_W'(col_q);
                    wait_load = 1'b1;
                    wait_val  = TW'(T_CL - 1);
                end
            end
            ST_READ: begin
                if (wait_done) begin
                    state_d = ST_IDLE;
                    valid_d = 1'b1;
                end
            end
            ST_REF: begin
                if (wait_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            valid_q <= valid_d;
        end
    end

    assign cmd   = cmd_q;
    assign addr  = addr_q;
    assign valid = valid_q;
    assign busy  = (state_q != ST_IDLE);

    // R6: the valid strobe coincides with the return to idle
    assert_valid_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !busy);

    // R3: a valid strobe lasts one cycle only
    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
    import sdram_rd_seq_pkg::*;
#(
    parameter int T_CL  = 5,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 8,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              ref_req,
    output logic [2:0]        sd_cmd,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              busy,
    output logic              rd_valid
);

    localparam int MAXT_A = (T_CL > T_RCD) ? T_CL : T_RCD;
    localparam int MAXT_B = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int MAXT   = (MAXT_A > MAXT_B) ? MAXT_A : MAXT_B;
    localparam int TW     = $clog2(MAXT + 1);
    localparam int SW     = $clog2(MAXT + 2) + 1;

    logic          wait_load, wait_done, ras_load, ras_done;
    logic [TW-1:0] wait_val;

    sdram_wait_timer #(.W(TW)) wait_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .done     (wait_done)
    );

    sdram_wait_timer #(.W(TW)) ras_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ras_load),
        .load_val (TW'(T_RAS - 1)),
        .done     (ras_done)
    );

    sdram_seq_fsm #(
        .T_CL  (T_CL),
        .T_RCD (T_RCD),
        .T_RP  (T_RP),
        .T_RAS (T_RAS),
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .TW    (TW)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .ref_req   (ref_req),
        .rd_row    (rd_row),
        .rd_col    (rd_col),
        .wait_done (wait_done),
        .ras_done  (ras_done),
        .wait_load (wait_load),
        .wait_val  (wait_val),
        .ras_load  (ras_load),
        .cmd       (sd_cmd),
        .addr      (sd_addr),
        .busy      (busy),
        .valid     (rd_valid)
    );

    // Spacing monitors on the command bus, saturating
    logic [SW-1:0] since_pre, since_act, since_rd, since_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= '1;
            since_act <= '1;
            since_rd  <= '1;
            since_row <= '1;
        end else begin
            since_pre <= (sd_cmd == CMD_PRE)  ? SW'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
            since_act <= (sd_cmd == CMD_ACT)  ? SW'(1) : ((since_act == '1) ? since_act : since_act + 1'b1);
            since_rd  <= (sd_cmd == CMD_READ) ? SW'(1) : ((since_rd  == '1) ? since_rd  : since_rd  + 1'b1);
            since_row <= (sd_cmd == CMD_ACT || sd_cmd == CMD_REF) ? SW'(1)
                       : ((since_row == '1) ? since_row : since_row + 1'b1);
        end
    end

    // R2: only the five defined encodings appear on the bus
    assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_NOP || sd_cmd == CMD_PRE || sd_cmd == CMD_ACT ||
         sd_cmd == CMD_READ || sd_cmd == CMD_REF));

    // R2: activate follows precharge by T_RP
    assert_act_after_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_ACT) |-> (since_pre == SW'(T_RP)));

    // R2: read follows activate by T_RCD
    assert_read_after_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_READ) |-> (since_act == SW'(T_RCD)));

    // R3: valid follows read by T_CL
    assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (since_rd == SW'(T_CL)));

    // R4: row open time respected before precharge
    assert_row_open_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_PRE) |-> (since_row >= SW'(T_RAS)));

    // R5: refresh follows precharge by T_RP
    assert_ref_after_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_REF) |-> (since_pre == SW'(T_RP)));

endmodule

// File: tb/sdram_rd_seq_tb.sv
module sdram_rd_seq_tb_top;

    localparam logic [2:0] C_NOP = 3'b111;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_REF = 3'b001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        rd_req  [2];
    logic        ref_req [2];
    logic [12:0] row     [2];
    logic [9:0]  col     [2];
    logic [2:0]  cmd     [2];
    logic [12:0] addr    [2];
    logic        busy    [2];
    logic        dv      [2];

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int last_row [2];
    bit wd_hit = 0;

    always @(posedge clk) cyc <= cyc + 1;

    sdram_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req[0]), .rd_row(row[0]), .rd_col(col[0]),
        .ref_req(ref_req[0]), .sd_cmd(cmd[0]), .sd_addr(addr[0]), .busy(busy[0]), .rd_valid(dv[0])
    );

    sdram_rd_seq #(.T_CL(5), .T_RCD(5), .T_RP(5), .T_RAS(12)) dut_slow_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req[1]), .rd_row(row[1]), .rd_col(col[1]),
        .ref_req(ref_req[1]), .sd_cmd(cmd[1]), .sd_addr(addr[1]), .busy(busy[1]), .rd_valid(dv[1])
    );

    function automatic int t_rp(int k);  return (k == 0) ? 3 : 5;  endfunction
    function automatic int t_rcd(int k); return (k == 0) ? 3 : 5;  endfunction
    function automatic int t_cl(int k);  return 5;                 endfunction
    function automatic int t_ras(int k); return (k == 0) ? 8 : 12; endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    // Idle cycles: nothing on the bus
    task automatic idle(int k, int g);
        for (int i = 0; i < g; i++) begin
            @(negedge clk);
            chk(cmd[k] == C_NOP, "R2", "idle cmd", int'(cmd[k]), int'(C_NOP));
            chk(busy[k] == 1'b0, "R6", "idle busy", int'(busy[k]), 0);
            chk(dv[k] == 1'b0, "R3", "idle valid", int'(dv[k]), 0);
        end
    endtask

    // One operation, called at a negedge where busy[k] is low
    task automatic do_op(int k, bit refq, bit rdq, logic [12:0] r, logic [9:0] c, bit junk);
        int n, pre, act_c, rd_c, ref_c, end_c;
        string tag;
        logic [2:0]  ecmd;
        logic [12:0] eaddr;
        n = cyc;
        pre = n + 1;
        if (last_row[k] + t_ras(k) > pre) pre = last_row[k] + t_ras(k);
        act_c = -1; rd_c = -1; ref_c = -1;
        if (refq) begin
            ref_c = pre + t_rp(k);
            end_c = ref_c + t_ras(k);
            last_row[k] = ref_c;
            tag = rdq ? "R7" : "R5";
        end else begin
            act_c = pre + t_rp(k);
            rd_c  = act_c + t_rcd(k);
            end_c = rd_c + t_cl(k);
            last_row[k] = act_c;
            tag = (k == 1) ? "R8" : ((pre > n + 1) ? "R4" : "R2");
        end
        if (pre > n + 1 && k == 1) tag = "R4";
        rd_req[k] = rdq; ref_req[k] = refq; row[k] = r; col[k] = c;
        for (int t = n + 1; t <= end_c; t++) begin
            @(negedge clk);
            if (junk && t < end_c) begin
                rd_req[k]  = 1'($urandom);
                ref_req[k] = 1'($urandom);
                row[k]     = 13'($urandom);
                col[k]     = 10'($urandom);
            end else begin
                rd_req[k] = 1'b0; ref_req[k] = 1'b0;
            end
            ecmd = C_NOP; eaddr = '0;
            if (t == pre) ecmd = C_PRE;
            else if (t == act_c) begin ecmd = C_ACT; eaddr = r; end
            else if (t == rd_c) begin ecmd = C_RD; eaddr = {3'b000, c}; end
            else if (t == ref_c) ecmd = C_REF;
            chk(cmd[k] == ecmd, tag, "cmd", int'(cmd[k]), int'(ecmd));
            chk(addr[k] == eaddr, tag, "addr", int'(addr[k]), int'(eaddr));
            chk(busy[k] == (t < end_c), junk ? "R6" : tag, "busy", int'(busy[k]), int'(t < end_c));
            chk(dv[k] == (t == end_c && !refq), refq ? tag : "R3", "valid",
                int'(dv[k]), int'(t == end_c && !refq));
        end
    endtask

    task automatic main_seq();
        for (int k = 0; k < 2; k++) begin
            rd_req[k] = 0; ref_req[k] = 0; row[k] = '0; col[k] = '0;
            last_row[k] = -1000;
        end
        void'($urandom(32'h1d5e_0a11));
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(cmd[k] == C_NOP, "R1", "reset cmd", int'(cmd[k]), int'(C_NOP));
            chk(busy[k] == 1'b0, "R1", "reset busy", int'(busy[k]), 0);
            chk(dv[k] == 1'b0, "R1", "reset valid", int'(dv[k]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd[0] == C_NOP && !busy[0] && !dv[0], "R1", "post-reset idle",
            int'({cmd[0], busy[0], dv[0]}), int'({C_NOP, 2'b00}));
        // directed: extreme addresses, back-to-back reads (R3)
        do_op(0, 0, 1, 13'h1fff, 10'h3ff, 0);
        do_op(0, 0, 1, 13'h0000, 10'h000, 0);
        do_op(0, 0, 1, 13'h0a5a, 10'h155, 0);
        idle(0, 2);
        // refresh, then read right after it (R5)
        do_op(0, 1, 0, 13'h0, 10'h0, 0);
        do_op(0, 0, 1, 13'h1234, 10'h2aa, 0);
        // simultaneous refresh and read: refresh wins (R7)
        idle(0, 1);
        do_op(0, 1, 1, 13'h0777, 10'h0ff, 0);
        // requests during busy ignored (R6)
        do_op(0, 0, 1, 13'h0f0f, 10'h0c3, 1);
        do_op(0, 1, 0, 13'h0, 10'h0, 1);
        idle(0, 3);
        // slow part: back-to-back read exercises the row guard (R8, R4)
        do_op(1, 0, 1, 13'h0101, 10'h011, 0);
        do_op(1, 0, 1, 13'h1f00, 10'h300, 0);
        do_op(1, 1, 0, 13'h0, 10'h0, 0);
        do_op(1, 0, 1, 13'h0042, 10'h024, 1);
        idle(1, 2);
        // constrained random on the default part
        for (int i = 0; i < 80; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            do_op(0, sel < 2, sel != 0, 13'($urandom), 10'($urandom), sel > 6);
            idle(0, int'($urandom_range(0, 3)));
        end
        // random on the slow part, gap zero often hits the guard (R4)
        for (int i = 0; i < 20; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            do_op(1, sel < 2, sel != 0, 13'($urandom), 10'($urandom), sel > 7);
            idle(1, int'($urandom_range(0, 2)));
        end
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule